// File: doc/BRIEF.md
# Output-Driver Calibration Control

This block is the device-side logic that services off-chip-driver calibration on a DDR2-class memory die. It watches a decoded command stream together with the address bus. A write to the first extended mode register carries a three-bit calibration field. That field can ask for one of four things:

- drive all data and strobe pins to a fixed high level, so the controller can measure the driver's impedance;
- drive those pins to a fixed low level, for the same purpose;
- take a four-beat adjustment burst that nudges the driver impedance codes;
- release the pins or restore the codes to their default.

Drive changes, both on and off, take effect a fixed `TOIT` clock cycles after the command. An adjustment burst arrives at the write latency, which is the additive latency carried in the command plus the CAS latency from the last mode-register write, minus one. Each beat steps a saturating pull-up code and a saturating pull-down code. The beats are applied in arrival order whatever burst ordering is programmed. Adjustment is refused and flagged when the programmed burst length is not four.

A controller uses the block in three steps. It first enters a drive mode to measure the output impedance. It then issues one or more adjust commands, each followed by a burst of step codes. Finally it issues the exit command.

Top module: `drvcal_top`

## Requirements
- R1: Reset gives `outEn`=0, every forced output 0, `puCode`=`pdCode`=midpoint (1000 binary when `CODE_W`=4) and `adjErr`=0. The latched mode settings reset to burst length four and CAS latency three, so an adjust with additive latency 0 has a write latency of 2.
- R2: Command encoding on `cmd` is 00 none, 01 mode register, 10 extended mode register 1 and 11 other. An extended-mode command whose calibration field `addr[9:7]` is 001 (drive high) or 010 (drive low) turns `outEn` on exactly `TOIT` cycles after the clock edge that samples it, and not earlier.
- R3: In drive-high every `dqOut` bit is 1, `dqsOut`=1 and `dqsNOut`=0. In drive-low every `dqOut` bit is 0, `dqsOut`=0 and `dqsNOut`=1. Whenever `outEn`=0 all three outputs are 0. A switch from one drive level to the other also lands `TOIT` cycles after its command.
- R4: Calibration field 000 (exit), 100 (adjust) or 111 (default) turns `outEn` off exactly `TOIT` cycles after the command edge.
- R5: A mode-register command latches burst length from `addr[2:0]` (010 means four) and CAS latency from `addr[6:4]`. An adjust command (field 100) takes additive latency from its own `addr[5:3]`. Its four beats are sampled on the clock edges WL, WL+1, WL+2 and WL+3 after the command edge, where WL = AL+CL-1.
- R6: A beat is read from `dq[3:0]`. Bit 0 raises `pdCode` by one and bit 1 lowers it. Bit 2 raises `puCode` by one and bit 3 lowers it. When both bits of a pair are set, that code is left unchanged.
- R7: Both codes saturate at 0 and at 2^`CODE_W`-1 and never wrap.
- R8: Beats are applied in arrival order. The burst-ordering bit `addr[3]` of the mode register has no effect on the result, and this is visible when saturation makes the order matter.
- R9: A beat is ignored when `dm`=1, or when `dqs` holds the value it had at the previous clock edge (no strobe transition).
- R10: An adjust command issued while the latched burst length is not four sets `adjErr` and captures no beats. The next accepted calibration command recomputes `adjErr`.
- R11: Field 111 sets both codes to the midpoint on the command's own clock edge.
- R12: Fields 011, 101 and 110 change neither the drive state nor the codes. Strobe transitions outside an adjust window change no code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmd | input | 2 | Decoded command: 00 none, 01 mode register, 10 extended mode register 1, 11 other |
| addr | input | ADDR_W | Address bus carrying mode fields |
| dq | input | DQ_W | Data input; bits 3:0 carry adjust beats |
| dqs | input | 1 | Data strobe input; each transition marks a beat |
| dm | input | 1 | Data mask; 1 drops the beat |
| outEn | output | 1 | Output drivers enabled |
| dqOut | output | DQ_W | Forced data level |
| dqsOut | output | 1 | Forced true-strobe level |
| dqsNOut | output | 1 | Forced complement-strobe level |
| puCode | output | CODE_W | Pull-up impedance code |
| pdCode | output | CODE_W | Pull-down impedance code |
| adjErr | output | 1 | Adjust refused because burst length is not four |

## Verification
The timing properties assume that calibration commands are spaced more than `TOIT` cycles apart, so a drive change can always be traced to a single command. The bench always waits at least `TOIT`+1 cycles between commands that move the drive state. The write-latency arithmetic assumes a CAS latency of at least two. The stimulus only programs latencies from two to five, and it holds `dqs` steady for at least one edge before each adjust window opens.

// File: rtl/drvcal_pkg.sv
package drvcal_pkg;

  localparam logic [1:0] CMD_NOP   = 2'b00;
  localparam logic [1:0] CMD_MRS   = 2'b01;
  localparam logic [1:0] CMD_EMRS1 = 2'b10;

  localparam logic [2:0] CAL_EXIT    = 3'b000;
  localparam logic [2:0] CAL_DRV_HI  = 3'b001;
  localparam logic [2:0] CAL_DRV_LO  = 3'b010;
  localparam logic [2:0] CAL_ADJUST  = 3'b100;
  localparam logic [2:0] CAL_DEFAULT = 3'b111;

  localparam int BL_LSB  = 0;
  localparam int CL_LSB  = 4;
  localparam int AL_LSB  = 3;
  localparam int CAL_LSB = 7;
  localparam logic [2:0] BL_FOUR = 3'b010;

  localparam int BEAT_W = 4;

  typedef enum logic [1:0] {
    DRV_OFF = 2'b00,
    DRV_HI  = 2'b01,
    DRV_LO  = 2'b10
  } drv_e;

  typedef struct packed {
    logic driveLoad;
    drv_e driveTarget;
    logic beatSlot;
    logic codeReset;
  } ctlStrobe_t;

endpackage

// File: rtl/drvcal_ctrl.sv
module drvcal_ctrl
  import drvcal_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int TOIT   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobe_t        strobe,
  output logic              adjErr
);

  localparam int DLY_W = $clog2(TOIT + 1);
  localparam int WL_W  = 4;

  logic [2:0] blReg;
  logic [2:0] clReg;
  logic [2:0] calField;
  logic [2:0] alField;
  logic       isMrs;
  logic       isEmrs;
  logic       calValid;
  logic       calCmd;
  logic       adjOk;
  drv_e       targetNow;
  drv_e       pendTarget;
  logic [DLY_W-1:0] dlyCnt;
  logic [WL_W-1:0]  wlNow;
  logic [WL_W-1:0]  waitCnt;
  logic [1:0]       beatIdx;
  logic             winActive;
  logic             unusedAddrBits;

  assign unusedAddrBits = ^addr;

  assign isMrs    = (cmd == CMD_MRS);
  assign isEmrs   = (cmd == CMD_EMRS1);
  assign calField = addr[CAL_LSB +: 3];
  assign alField  = addr[AL_LSB +: 3];

  always_comb begin
    case (calField)
      CAL_EXIT, CAL_DRV_HI, CAL_DRV_LO, CAL_ADJUST, CAL_DEFAULT: calValid = 1'b1;
      default: calValid = 1'b0;
    endcase
  end

  always_comb begin
    case (calField)
      CAL_DRV_HI: targetNow = DRV_HI;
      CAL_DRV_LO: targetNow = DRV_LO;
      default:    targetNow = DRV_OFF;
    endcase
  end

  assign calCmd = isEmrs && calValid;
  assign adjOk  = (calField == CAL_ADJUST) && (blReg == BL_FOUR);
  assign wlNow  = WL_W'(alField) + WL_W'(clReg) - WL_W'(1);

  // Mode settings latched from the plain mode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blReg <= BL_FOUR;
      clReg <= 3'd3;
    end else if (isMrs) begin
      blReg <= addr[BL_LSB +: 3];
      clReg <= addr[CL_LSB +: 3];
    end
  end

  // Drive on/off delay line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyCnt     <= '0;
      pendTarget <= DRV_OFF;
    end else if (calCmd) begin
      dlyCnt     <= DLY_W'(TOIT);
      pendTarget <= targetNow;
    end else if (dlyCnt != '0) begin
      dlyCnt <= dlyCnt - 1'b1;
    end
  end

  // Adjust window sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winActive <= 1'b0;
      waitCnt   <= '0;
      beatIdx   <= '0;
      adjErr    <= 1'b0;
    end else if (calCmd) begin
      winActive <= adjOk;
      waitCnt   <= wlNow - WL_W'(1);
      beatIdx   <= '0;
      adjErr    <= (calField == CAL_ADJUST) && (blReg != BL_FOUR);
    end else if (winActive) begin
      if (waitCnt != '0) begin
        waitCnt <= waitCnt - 1'b1;
      end else begin
        beatIdx <= beatIdx + 1'b1;
        if (beatIdx == 2'd3) winActive <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.driveLoad   = (dlyCnt == DLY_W'(1));
    strobe.driveTarget = pendTarget;
    strobe.beatSlot    = winActive && (waitCnt == '0);
    strobe.codeReset   = calCmd && (calField == CAL_DEFAULT);
  end

endmodule

// File: rtl/drvcal_dp.sv
module drvcal_dp
  import drvcal_pkg::*;
#(
  parameter int DQ_W   = 4,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DQ_W-1:0]   dq,
  input  logic              dqs,
  input  logic              dm,
  output logic              outEn,
  output logic [DQ_W-1:0]   dqOut,
  output logic              dqsOut,
  output logic              dqsNOut,
  output logic [CODE_W-1:0] puCode,
  output logic [CODE_W-1:0] pdCode
);

  localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam int N_CHAN = 2;

  drv_e              driveState;
  logic              prevDqs;
  logic              beatTake;
  logic [BEAT_W-1:0] beat;
  logic              driveOn;
  logic              driveHi;
  logic              unusedDq;

  assign unusedDq = ^dq;
  assign beat     = dq[BEAT_W-1:0];
  assign beatTake = strobe.beatSlot && (dqs != prevDqs) && !dm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveState <= DRV_OFF;
      prevDqs    <= 1'b0;
    end else begin
      prevDqs <= dqs;
      if (strobe.driveLoad) driveState <= strobe.driveTarget;
    end
  end

  // Channel 0 is pull-down (beat bits 1:0), channel 1 is pull-up (bits 3:2)
  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
    logic              incr;
    logic              decr;
    logic [CODE_W-1:0] codeQ;

    assign incr = beat[2*g];
    assign decr = beat[2*g+1];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        codeQ <= CODE_MID;
      end else if (strobe.codeReset) begin
        codeQ <= CODE_MID;
      end else if (beatTake && incr && !decr && (codeQ != CODE_MAX)) begin
        codeQ <= codeQ + 1'b1;
      end else if (beatTake && decr && !incr && (codeQ != '0)) begin
        codeQ <= codeQ - 1'b1;
      end
    end
  end

  assign pdCode  = g_chan[0].codeQ;
  assign puCode  = g_chan[1].codeQ;

  assign driveOn = (driveState != DRV_OFF);
  assign driveHi = (driveState == DRV_HI);
  assign outEn   = driveOn;
  assign dqOut   = {DQ_W{driveOn && driveHi}};
  assign dqsOut  = driveOn && driveHi;
  assign dqsNOut = driveOn && !driveHi;

endmodule

// File: rtl/drvcal_top.sv
module drvcal_top
  import drvcal_pkg::*;
#(
  parameter int DQ_W   = 4,
  parameter int CODE_W = 4,
  parameter int ADDR_W = 14,
  parameter int TOIT   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq,
  input  logic              dqs,
  input  logic              dm,
  output logic              outEn,
  output logic [DQ_W-1:0]   dqOut,
  output logic              dqsOut,
  output logic              dqsNOut,
  output logic [CODE_W-1:0] puCode,
  output logic [CODE_W-1:0] pdCode,
  output logic              adjErr
);

  ctlStrobe_t strobe;

  drvcal_ctrl #(
    .ADDR_W(ADDR_W),
    .TOIT  (TOIT)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .cmd   (cmd),
    .addr  (addr),
    .strobe(strobe),
    .adjErr(adjErr)
  );

  drvcal_dp #(
    .DQ_W  (DQ_W),
    .CODE_W(CODE_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .dq     (dq),
    .dqs    (dqs),
    .dm     (dm),
    .outEn  (outEn),
    .dqOut  (dqOut),
    .dqsOut (dqsOut),
    .dqsNOut(dqsNOut),
    .puCode (puCode),
    .pdCode (pdCode)
  );

endmodule

// File: rtl/drvcal_checker.sv
module drvcal_checker #(
  parameter int DQ_W   = 4,
  parameter int CODE_W = 4,
  parameter int ADDR_W = 14,
  parameter int TOIT   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic              outEn,
  input logic [DQ_W-1:0]   dqOut,
  input logic              dqsOut,
  input logic              dqsNOut,
  input logic [CODE_W-1:0] puCode,
  input logic [CODE_W-1:0] pdCode,
  input logic              adjErr
);

  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic       calSeen;
  logic       dfltSeen;
  logic [7:0] sinceCal;

  assign calSeen  = (cmd == 2'b10) &&
                    (addr[9:7] inside {3'b000, 3'b001, 3'b010, 3'b100, 3'b111});
  assign dfltSeen = (cmd == 2'b10) && (addr[9:7] == 3'b111);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceCal <= 8'hFF;
    else if (calSeen)          sinceCal <= 8'd0;
    else if (sinceCal != 8'hFF) sinceCal <= sinceCal + 8'd1;
  end

  a_r2_drive_on_delay: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outEn) |-> (sinceCal == 8'(TOIT)));

  a_r4_drive_off_delay: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outEn) |-> (sinceCal == 8'(TOIT)));

  a_r3_levels_on: assert property (@(posedge clk) disable iff (!rstN)
    outEn |-> ((dqsOut != dqsNOut) && (dqOut == {DQ_W{dqsOut}})));

  a_r3_levels_off: assert property (@(posedge clk) disable iff (!rstN)
    !outEn |-> (!dqsOut && !dqsNOut && (dqOut == '0)));

  a_r7_pu_step: assert property (@(posedge clk) disable iff (!rstN)
    (puCode != $past(puCode)) |->
      (({1'b0, puCode} == {1'b0, $past(puCode)} + 1'b1) ||
       ({1'b0, puCode} == {1'b0, $past(puCode)} - 1'b1) || (puCode == MID)));

  a_r7_pd_step: assert property (@(posedge clk) disable iff (!rstN)
    (pdCode != $past(pdCode)) |->
      (({1'b0, pdCode} == {1'b0, $past(pdCode)} + 1'b1) ||
       ({1'b0, pdCode} == {1'b0, $past(pdCode)} - 1'b1) || (pdCode == MID)));

  a_r10_err_holds_codes: assert property (@(posedge clk) disable iff (!rstN)
    adjErr |-> ($stable(puCode) && $stable(pdCode)));

  a_r11_default_mid: assert property (@(posedge clk) disable iff (!rstN)
    dfltSeen |=> ((puCode == MID) && (pdCode == MID)));

endmodule

bind drvcal_top drvcal_checker #(
  .DQ_W  (DQ_W),
  .CODE_W(CODE_W),
  .ADDR_W(ADDR_W),
  .TOIT  (TOIT)
) u_check (
  .clk    (clk),
  .rstN   (rstN),
  .cmd    (cmd),
  .addr   (addr),
  .outEn  (outEn),
  .dqOut  (dqOut),
  .dqsOut (dqsOut),
  .dqsNOut(dqsNOut),
  .puCode (puCode),
  .pdCode (pdCode),
  .adjErr (adjErr)
);

// File: tb/drvcal_top_test.sv
module drvcal_top_test;

  localparam int DQ_W = 4, CODE_W = 4, ADDR_W = 14, TOIT = 2;
  localparam logic [1:0] C_MRS = 2'b01, C_EMRS = 2'b10;

  typedef struct packed {
    logic [2:0]  cl;
    logic [2:0]  al;
    logic        itl;
    logic [15:0] beats;
    logic [3:0]  dmMask;
    logic [3:0]  expPu;
    logic [3:0]  expPd;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{3'd3, 3'd0, 1'b0, 16'h0411, 4'b0000, 4'd9,  4'd10},
    '{3'd4, 3'd1, 1'b0, 16'h2882, 4'b0000, 4'd6,  4'd6},
    '{3'd2, 3'd0, 1'b0, 16'h95C3, 4'b0000, 4'd8,  4'd10},
    '{3'd3, 3'd2, 1'b0, 16'h1111, 4'b0101, 4'd8,  4'd10},
    '{3'd5, 3'd0, 1'b1, 16'h1844, 4'b0000, 4'd9,  4'd9}
  };

  logic clk = 0, rstN = 0;
  logic [1:0] cmd = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DQ_W-1:0] dq = '0;
  logic dqs = 0, dm = 0;
  logic outEn, dqsOut, dqsNOut, adjErr;
  logic [DQ_W-1:0] dqOut;
  logic [CODE_W-1:0] puCode, pdCode;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  drvcal_top #(.DQ_W(DQ_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .TOIT(TOIT)) uut (
    .clk(clk), .rstN(rstN), .cmd(cmd), .addr(addr), .dq(dq), .dqs(dqs), .dm(dm),
    .outEn(outEn), .dqOut(dqOut), .dqsOut(dqsOut), .dqsNOut(dqsNOut),
    .puCode(puCode), .pdCode(pdCode), .adjErr(adjErr));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [ADDR_W-1:0] mrsAddr(input int cl, input int bl, input int itl);
    return ADDR_W'((cl << 4) | (itl << 3) | bl);
  endfunction

  function automatic logic [ADDR_W-1:0] emrsAddr(input int fld, input int al);
    return ADDR_W'((fld << 7) | (al << 3));
  endfunction

  task automatic sendCmd(input logic [1:0] c, input logic [ADDR_W-1:0] a);
    cmd = c; addr = a;
    tick();
    cmd = '0; addr = '0;
  endtask

  task automatic doAdjust(input int al, input int wl, input logic [15:0] beats,
                          input logic [3:0] dmMask);
    sendCmd(C_EMRS, emrsAddr(4, al));
    repeat (wl - 1) tick();
    for (int i = 0; i < 4; i++) begin
      dqs = ~dqs;
      dq  = beats[4*i +: 4];
      dm  = dmMask[i];
      tick();
    end
    dq = '0; dm = 0;
    tick();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish();
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    check("R1 outEn", outEn, 0);
    check("R1 dqOut", dqOut, 0);
    check("R1 dqsOut", dqsOut, 0);
    check("R1 dqsNOut", dqsNOut, 0);
    check("R1 puCode", puCode, 8);
    check("R1 pdCode", pdCode, 8);
    check("R1 adjErr", adjErr, 0);
    rstN = 1;
    tick();
    // R1 reset mode settings: BL4, CL3 -> WL 2 with AL 0
    doAdjust(0, 2, 16'h0001, 4'b0000);
    check("R1 R5 reset latency pdCode", pdCode, 9);
    sendCmd(C_EMRS, emrsAddr(7, 0));

    // Vector table: R5 R6 R8 R9
    foreach (VEC[v]) begin
      sendCmd(C_MRS, mrsAddr(VEC[v].cl, 2, VEC[v].itl));
      sendCmd(C_EMRS, emrsAddr(7, 0));
      doAdjust(VEC[v].al, VEC[v].al + VEC[v].cl - 1, VEC[v].beats, VEC[v].dmMask);
      check($sformatf("R5 R6 R8 R9 vec%0d puCode", v), puCode, VEC[v].expPu);
      check($sformatf("R5 R6 R8 R9 vec%0d pdCode", v), pdCode, VEC[v].expPd);
    end

    // R2 drive-high entry timing, R3 levels
    sendCmd(C_EMRS, emrsAddr(1, 0));
    check("R2 off at cmd edge", outEn, 0);
    tick();
    check("R2 off at TOIT-1", outEn, 0);
    tick();
    check("R2 on at TOIT", outEn, 1);
    check("R3 hi dqOut", dqOut, 15);
    check("R3 hi dqsOut", dqsOut, 1);
    check("R3 hi dqsNOut", dqsNOut, 0);
    // R12 reserved field ignored
    sendCmd(C_EMRS, emrsAddr(3, 0));
    repeat (3) tick();
    check("R12 reserved keeps outEn", outEn, 1);
    check("R12 reserved keeps dqOut", dqOut, 15);
    check("R12 reserved keeps puCode", puCode, 9);
    // R3 switch to drive-low
    sendCmd(C_EMRS, emrsAddr(2, 0));
    tick();
    check("R3 still high before TOIT", dqOut, 15);
    tick();
    check("R3 lo outEn", outEn, 1);
    check("R3 lo dqOut", dqOut, 0);
    check("R3 lo dqsOut", dqsOut, 0);
    check("R3 lo dqsNOut", dqsNOut, 1);
    // R4 exit
    repeat (2) tick();
    sendCmd(C_EMRS, emrsAddr(0, 0));
    tick();
    check("R4 on before TOIT", outEn, 1);
    tick();
    check("R4 off at TOIT", outEn, 0);
    check("R4 dqsNOut off", dqsNOut, 0);

    // R7 saturation and R8 order
    sendCmd(C_MRS, mrsAddr(3, 2, 0));
    sendCmd(C_EMRS, emrsAddr(7, 0));
    doAdjust(0, 2, 16'h6666, 4'b0000);
    doAdjust(0, 2, 16'h6666, 4'b0000);
    check("R7 pu saturates high", puCode, 15);
    check("R7 pd saturates low", pdCode, 0);
    doAdjust(0, 2, 16'h0096, 4'b0000);
    check("R7 R8 pu ordered", puCode, 14);
    check("R7 R8 pd ordered", pdCode, 1);

    // R11 default
    sendCmd(C_EMRS, emrsAddr(7, 0));
    check("R11 pu mid", puCode, 8);
    check("R11 pd mid", pdCode, 8);

    // R9 beat without strobe transition ignored
    dqs = 0;
    tick();
    sendCmd(C_EMRS, emrsAddr(4, 0));
    tick();
    dqs = 1; dq = 4'h1; tick();
    dqs = 1; dq = 4'h1; tick();
    dqs = 0; dq = 4'h0; tick();
    dqs = 1; dq = 4'h0; tick();
    dq = '0;
    tick();
    check("R9 no toggle pdCode", pdCode, 9);

    // R12 strobes outside window ignored
    for (int i = 0; i < 4; i++) begin
      dqs = ~dqs; dq = 4'h4; tick();
    end
    dq = '0;
    tick();
    check("R12 outside window puCode", puCode, 8);
    check("R12 outside window pdCode", pdCode, 9);

    // R10 burst length not four
    sendCmd(C_MRS, mrsAddr(3, 3, 0));
    doAdjust(0, 2, 16'h1111, 4'b0000);
    check("R10 adjErr set", adjErr, 1);
    check("R10 no capture pdCode", pdCode, 9);
    sendCmd(C_MRS, mrsAddr(3, 2, 0));
    sendCmd(C_EMRS, emrsAddr(7, 0));
    check("R10 adjErr cleared", adjErr, 0);

    repeat (3) tick();
    finish();
  end

endmodule